// File: doc/BRIEF.md
# Queued Scatter-Gather Memory Copy Engine

This block copies words from one region of physical memory to another so that a host processor does not have to issue the individual loads and stores. The host posts transfer descriptors through a valid/ready command port into a small FIFO. Each descriptor carries a source word address, a destination word address, a word count and a "chain continues" flag. The engine takes descriptors strictly in the order they were accepted. For each word it reads the source location, holds the value in a one-word buffer and writes it to the destination. Chained descriptors gather scattered source pieces into one contiguous destination region.

The engine shares a single word-wide memory master port with a CPU. A two-bit share-mode input selects one of three policies. In burst mode the engine keeps the bus for a whole descriptor. In cycle-stealing mode it hands the bus back after every word whenever the CPU is asking. In background mode it only uses cycles that the CPU leaves free. The memory answers a read combinationally in the cycle it is issued, and a write takes effect at the end of that cycle. Completion shows up as a one-cycle pulse at the end of each chain and as a running count of finished descriptors.

Top module: `qdma_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, `xfer_count` is 0 and `mem_req` is 0, and while the engine is idle `cpu_gnt` equals `cpu_req`.
- R2: A descriptor is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. The queue holds 4 descriptors besides the one being executed. When the queue is full, `cmd_ready` is 0 and a presented descriptor is dropped and never executed.
- R3: Descriptors execute one at a time, in the order they were accepted.
- R4: A descriptor of length L reads word `src+i` and then writes that same value to word `dst+i`, for i = 0 to L-1 in increasing order. A write (`mem_we`=1) always follows the read of the same word.
- R5: If a descriptor has `cmd_more`=1, the next descriptor ignores its own `cmd_dst` and writes starting at the word after the last destination word of the previous descriptor (unchanged if that one had length 0).
- R6: A descriptor of length 0 completes without raising `mem_req`.
- R7: `done` is high for exactly one cycle, in the cycle after a descriptor with `cmd_more`=0 completes. A descriptor with `cmd_more`=1 raises no pulse.
- R8: `xfer_count` increases by exactly one for every completed descriptor, including zero-length ones, and wraps modulo 2^CNT_W.
- R9: With `mode`=0 (burst), every access of a descriptor, from its first read to its last write, falls in consecutive cycles, so the CPU is given no cycle in between.
- R10: With `mode`=1 (cycle stealing), in a cycle that follows an engine write while `cpu_req` is 1, the engine makes no access and `cpu_gnt` is 1. The two accesses of one word are never split.
- R11: With `mode`=2 or 3 (background), `mem_req` is 0 in every cycle where `cpu_req` is 1.
- R12: `cpu_gnt` and `mem_req` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Bus share policy: 0 burst, 1 cycle stealing, 2/3 background; change only while idle |
| cmd_valid | input | 1 | Descriptor presented |
| cmd_ready | output | 1 | Queue can take a descriptor |
| cmd_src | input | ADDR_W | Source word address |
| cmd_dst | input | ADDR_W | Destination word address |
| cmd_len | input | LEN_W | Number of words |
| cmd_more | input | 1 | Another descriptor of the same chain follows |
| mem_req | output | 1 | Engine uses the memory port this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid in the cycle of the read |
| cpu_req | input | 1 | CPU wants the memory port |
| cpu_gnt | output | 1 | CPU owns the memory port this cycle |
| done | output | 1 | One-cycle end-of-chain pulse |
| xfer_count | output | CNT_W | Completed descriptor count |

## Verification
The assertions watch the sharing rules on every cycle. In background mode they check that no access coincides with a CPU request. In cycle-stealing mode they check that the engine backs off after a write when the CPU is asking. In burst mode they check that a read is always followed straight away by its write. They also check that the queue never overfills and that the counter moves by at most one, with every done pulse tied to a count step. Only the bench scenarios can show the end results. These are copied memory contents, destination continuation across chains, execution order through a full queue, dropped descriptors, access-free zero-length completion, and the span of whole burst and stealing transfers measured with the CPU asking throughout.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    parameter int unsigned ADDR_W = 16;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned LEN_W  = 8;

    localparam logic [1:0] MODE_BURST = 2'd0;
    localparam logic [1:0] MODE_STEAL = 2'd1;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic              more;
    } desc_t;

    localparam int unsigned DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_RD   = 2'd1,
        MV_WR   = 2'd2
    } mv_state_e;

endpackage

// File: rtl/qdma_fifo.sv
module qdma_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] rdata
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     do_push, do_pop;

    always_comb begin
        full    = (s_q.cnt == CW'(DEPTH));
        empty   = (s_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = s_q.mem[s_q.rp];
        s_d     = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R2

endmodule

// File: rtl/qdma_share.sv
module qdma_share
    import qdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cpu_req,
    input  logic       want,
    input  logic       phase_wr,
    output logic       go,
    output logic       cpu_gnt
);
    typedef struct packed {
        logic last_wr;
    } share_st_t;

    share_st_t s_d, s_q;
    logic      hold_bus;

    always_comb begin
        hold_bus = 1'b0;
        case (mode)
            MODE_BURST: begin
                go       = want;
                hold_bus = want;
            end
            MODE_STEAL: go = want && !(cpu_req && s_q.last_wr && !phase_wr);
            default:    go = want && !cpu_req;
        endcase
        cpu_gnt     = cpu_req && !go && !hold_bus;
        s_d.last_wr = go && phase_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
    import qdma_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  desc_t             head,
    input  logic              q_empty,
    output logic              q_pop,
    input  logic              go,
    output logic              want,
    output logic              phase_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        mv_state_e         st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  rem;
        logic              more;
        logic              chain;
        logic [DATA_W-1:0] hold;
        logic              done;
        logic [CNT_W-1:0]  cnt;
    } mv_st_t;

    mv_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        q_pop     = 1'b0;
        want      = (s_q.st != MV_IDLE);
        phase_wr  = (s_q.st == MV_WR);
        mem_addr  = phase_wr ? s_q.dst : s_q.src;
        mem_wdata = s_q.hold;
        case (s_q.st)
            MV_IDLE: begin
                if (!q_empty) begin
                    q_pop     = 1'b1;
                    s_d.src   = head.src;
                    s_d.dst   = s_q.chain ? s_q.dst : head.dst;
                    s_d.rem   = head.len;
                    s_d.more  = head.more;
                    s_d.chain = head.more;
                    if (head.len == '0) begin
                        s_d.done = !head.more;
                        s_d.cnt  = s_q.cnt + 1'b1;
                    end else begin
                        s_d.st = MV_RD;
                    end
                end
            end
            MV_RD: begin
                if (go) begin
                    s_d.hold = mem_rdata;
                    s_d.st   = MV_WR;
                end
            end
            MV_WR: begin
                if (go) begin
                    s_d.src = s_q.src + 1'b1;
                    s_d.dst = s_q.dst + 1'b1;
                    s_d.rem = s_q.rem - 1'b1;
                    if (s_q.rem == LEN_W'(1)) begin
                        s_d.st   = MV_IDLE;
                        s_d.done = !s_q.more;
                        s_d.cnt  = s_q.cnt + 1'b1;
                    end else begin
                        s_d.st = MV_RD;
                    end
                end
            end
            default: s_d.st = MV_IDLE;
        endcase
        done  = s_q.done;
        count = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == $past(s_q.cnt)) || (s_q.cnt == CNT_W'($past(s_q.cnt) + 1'b1))); // R8

    AST_DONE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count != $past(count))); // R7

endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
    import qdma_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_more,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cpu_req,
    output logic              cpu_gnt,
    output logic              done,
    output logic [CNT_W-1:0]  xfer_count
);
    desc_t             in_desc;
    logic [DESC_W-1:0] head_bits;
    desc_t             head;
    logic              q_full, q_empty, q_pop;
    logic              want, phase_wr, go;

    always_comb begin
        in_desc.src  = cmd_src;
        in_desc.dst  = cmd_dst;
        in_desc.len  = cmd_len;
        in_desc.more = cmd_more;
        head         = desc_t'(head_bits);
        cmd_ready    = !q_full;
        mem_req      = go;
        mem_we       = phase_wr;
    end

    qdma_fifo #(.W(DESC_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_valid),
        .wdata (in_desc),
        .full  (q_full),
        .pop   (q_pop),
        .empty (q_empty),
        .rdata (head_bits)
    );

    qdma_share u_share (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cpu_req  (cpu_req),
        .want     (want),
        .phase_wr (phase_wr),
        .go       (go),
        .cpu_gnt  (cpu_gnt)
    );

    qdma_mover #(.CNT_W(CNT_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head),
        .q_empty   (q_empty),
        .q_pop     (q_pop),
        .go        (go),
        .want      (want),
        .phase_wr  (phase_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .count     (xfer_count)
    );

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && $past(mode) == MODE_BURST && $past(mem_req && !mem_we))
        |-> (mem_req && mem_we)); // R9

    AST_STEAL_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STEAL && $past(mode) == MODE_STEAL && cpu_req && $past(mem_req && mem_we))
        |-> (!mem_req && cpu_gnt)); // R10

    AST_BG_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && cpu_req) |-> !mem_req); // R11

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && mem_req)); // R12

endmodule

// File: tb/tb_qdma_engine.sv
module tb_qdma_engine;
    import qdma_pkg::*;

    localparam int unsigned CNT_W = 8;
    localparam int MEMN = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_src = '0;
    logic [ADDR_W-1:0] cmd_dst = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              cmd_more = 1'b0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              cpu_req = 1'b0;
    logic              cpu_gnt, done;
    logic [CNT_W-1:0]  xfer_count;

    always #10 clk = ~clk;

    qdma_engine #(.FIFO_DEPTH(4), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src),
        .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_more(cmd_more),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .done(done), .xfer_count(xfer_count)
    );

    function automatic logic [31:0] init_val(int i);
        return (i < 512) ? (i * 32'h9E37_79B1) ^ 32'h0000_5A5A : 32'h0;
    endfunction

    // memory model: combinational read, write at clock edge
    logic [31:0] mem [MEMN];
    logic [31:0] exp_mem [MEMN];
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= init_val(i);
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    // cpu request driver
    logic rand_cpu = 1'b0;
    logic cpu_fixed = 1'b0;
    always @(negedge clk) cpu_req <= rand_cpu ? 1'($urandom_range(0, 1)) : cpu_fixed;

    // monitor, samples mid low phase
    logic clr = 1'b0;
    int   cyc = 0, n_acc = 0, n_done = 0, n_both = 0, n_bgconf = 0, first_acc = 0, last_acc = 0;
    always @(negedge clk) begin
        #5;
        cyc <= cyc + 1;
        if (clr) begin
            n_acc <= 0; n_done <= 0; n_bgconf <= 0;
        end else if (rst_n) begin
            if (mem_req) begin
                if (n_acc == 0) first_acc <= cyc;
                last_acc <= cyc;
                n_acc <= n_acc + 1;
            end
            if (done) n_done <= n_done + 1;
            if (mem_req && cpu_req && mode[1]) n_bgconf <= n_bgconf + 1;
            if (mem_req && cpu_gnt) n_both <= n_both + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    int exp_cnt = 0, exp_done = 0;
    bit chain_act = 1'b0;
    int chain_dst = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_stats();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_done = 0;
    endtask

    // reference model of one descriptor, applied in acceptance order
    task automatic model(input int src, input int dst, input int len, input bit more);
        int d;
        d = chain_act ? chain_dst : dst;
        for (int i = 0; i < len; i++) exp_mem[d + i] = exp_mem[src + i];
        chain_dst = d + len;
        chain_act = more;
        exp_cnt++;
        if (!more) exp_done++;
    endtask

    task automatic push(input int src, input int dst, input int len, input bit more);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = ADDR_W'(src); cmd_dst = ADDR_W'(dst);
        cmd_len = LEN_W'(len); cmd_more = more;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        model(src, dst, len, more);
    endtask

    task automatic wait_idle(input string req);
        int k;
        k = 0;
        while (xfer_count != CNT_W'(exp_cnt) && k < 3000) begin
            @(negedge clk); k++;
        end
        repeat (4) @(negedge clk);
        check(xfer_count == CNT_W'(exp_cnt), req, "descriptor count", xfer_count, exp_cnt & 255);
    endtask

    task automatic compare_mem(input string req);
        int bad, first;
        bad = 0; first = -1;
        for (int a = 0; a < MEMN; a++) begin
            if (mem[a] !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first < 0) check(1'b1, req, "memory image", 0, 0);
        else check(1'b0, req, $sformatf("memory word %0d", first), mem[first], exp_mem[first]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int ln, src, dst, cnt0;
        bit mr;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEMN; i++) exp_mem[i] = init_val(i);
        cpu_fixed = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(xfer_count == '0, "R1", "count after reset", xfer_count, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        check(cpu_gnt == cpu_req, "R1", "idle cpu_gnt", cpu_gnt, cpu_req);

        // R9 burst with CPU asking all the time
        mode = 2'd0;
        clear_stats();
        push(10, 600, 6, 1'b0);
        wait_idle("R9");
        check(n_acc == 12, "R4", "burst access count", n_acc, 12);
        check(last_acc - first_acc + 1 == 12, "R9", "burst span", last_acc - first_acc + 1, 12);
        check(n_done == 1, "R7", "burst done pulses", n_done, 1);
        compare_mem("R4");

        // R10 cycle stealing with CPU asking all the time
        mode = 2'd1;
        clear_stats();
        push(40, 620, 5, 1'b0);
        wait_idle("R10");
        check(last_acc - first_acc + 1 == 14, "R10", "stealing span", last_acc - first_acc + 1, 14);
        check(n_acc == 10, "R10", "stealing access count", n_acc, 10);
        compare_mem("R10");

        // R11 background: CPU holds the bus, engine must wait
        mode = 2'd2;
        clear_stats();
        push(60, 640, 4, 1'b0);
        repeat (30) @(negedge clk);
        check(n_acc == 0, "R11", "accesses while CPU asks", n_acc, 0);
        cpu_fixed = 1'b0;
        wait_idle("R11");
        check(n_acc == 8, "R11", "background access count", n_acc, 8);
        compare_mem("R11");

        // R5 gather chain with junk destinations after the first
        mode = 2'd0; cpu_fixed = 1'b1;
        clear_stats();
        cnt0 = exp_cnt;
        push(100, 700, 3, 1'b1);
        push(150, 999, 2, 1'b1);
        push(200, 5, 4, 1'b0);
        wait_idle("R5");
        check(exp_cnt - cnt0 == 3, "R8", "chain descriptors counted", exp_cnt - cnt0, 3);
        check(n_done == 1, "R7", "one pulse per chain", n_done, 1);
        compare_mem("R5");

        // R6 zero length alone and inside a chain
        clear_stats();
        push(0, 800, 0, 1'b0);
        wait_idle("R6");
        check(n_acc == 0, "R6", "zero-length accesses", n_acc, 0);
        check(n_done == 1, "R6", "zero-length done pulse", n_done, 1);
        clear_stats();
        push(20, 820, 2, 1'b1);
        push(0, 3, 0, 1'b1);
        push(30, 4, 2, 1'b0);
        wait_idle("R5");
        check(n_acc == 8, "R6", "chain with empty piece accesses", n_acc, 8);
        compare_mem("R5");

        // R2 / R3 full queue, dropped descriptor, ordering
        mode = 2'd2; cpu_fixed = 1'b1;
        clear_stats();
        cnt0 = exp_cnt;
        push(70, 860, 10, 1'b0);
        repeat (3) @(negedge clk);
        push(1, 900, 1, 1'b0);
        push(2, 900, 1, 1'b0);
        push(3, 900, 1, 1'b0);
        push(4, 900, 1, 1'b0);
        check(cmd_ready == 1'b0, "R2", "ready with full queue", cmd_ready, 0);
        cmd_src = 16'd5; cmd_dst = 16'd910; cmd_len = 8'd3; cmd_more = 1'b0;
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        cpu_fixed = 1'b0;
        wait_idle("R2");
        repeat (20) @(negedge clk);
        check(xfer_count == CNT_W'(cnt0 + 5), "R2", "dropped descriptor not run", xfer_count, (cnt0 + 5) & 255);
        check(mem[910] == 32'h0, "R2", "dropped destination untouched", mem[910], 0);
        check(mem[900] == exp_mem[900], "R3", "last writer in order", mem[900], exp_mem[900]);
        compare_mem("R3");

        // randomized batches in each share mode
        rand_cpu = 1'b1;
        for (int b = 0; b < 3; b++) begin
            mode = 2'(b);
            clear_stats();
            for (int k = 0; k < 8; k++) begin
                ln  = $urandom_range(0, 6);
                src = $urandom_range(0, 240);
                dst = $urandom_range(512, 950);
                mr  = (k != 7) && ($urandom_range(0, 2) == 0);
                push(src, dst, ln, mr);
            end
            wait_idle("R8");
            check(n_done == exp_done, "R7", "random done pulses", n_done, exp_done);
            compare_mem("R4");
            if (b == 2) check(n_bgconf == 0, "R11", "random background conflicts", n_bgconf, 0);
        end
        rand_cpu = 1'b0;
        repeat (3) @(negedge clk);
        check(n_both == 0, "R12", "cpu_gnt with mem_req", n_both, 0);
        summary();
    end

endmodule